// File: doc/BRIEF.md
# GPIO controller with edge-sensed interrupts

This block is a 32-line general-purpose I/O port placed behind a simple register port. Software sets each line's direction, writes an output latch, reads back the line levels, and is told about pin changes through a sticky event register and a single combined interrupt. Every input passes through a two-flop synchronizer. A third registered copy then serves as the reference for edge detection. A qualifying edge sets the event bit of its line, and the bit stays set until software writes a one to it.

In every register, bit `31-n` belongs to line `n`, so line 0 sits in the most significant bit. The pin ports are indexed by line number. The edge sense is chosen at build time. In the one-bit variant there is one control bit per line. In the two-bit variant there is a field of two bits per line, and the fields are spread over two control words. A parameter names the lines that may only ever be inputs.

The register port has no back-pressure. A write is taken on every clock edge at which `bus_valid` and `bus_write` are both high. `bus_rdata` is combinational and always shows the register selected by `bus_addr`. Unaligned and unmapped offsets read zero, and writes to them are ignored.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Register bit `31-n` controls and reports line `n` in every register. A data word of 0x8000_0000 with line 0 set as an output drives `pin_out[0]` high.
- R2: Offset 0x00 is direction, and a bit of 1 makes the line an output. `pin_oe` equals the direction register in line order. `pin_out` equals the output latch in line order. A write to offset 0x08 changes only the output latch.
- R3: A read of offset 0x08 returns the latch bit for output lines and the synchronized pin level for input lines. A pin change shows up in the read two clock edges after the change.
- R4: In the event register at offset 0x0C, writing 1 clears a bit and writing 0 leaves it unchanged. When an edge qualifies in the same cycle as its clear, the bit stays set.
- R5: `irq` is high exactly when (event AND mask) is nonzero. The mask register is at offset 0x10, and a mask bit of 1 enables its line.
- R6: In the one-bit sense variant, a bit of 1 in the control word at offset 0x14 selects falling edges only, and a bit of 0 selects both edges.
- R7: In the two-bit sense variant, lines 0–15 use offset 0x14 and lines 16–31 use offset 0x18. Line `n` uses bits `[(15-(n mod 16))*2 +: 2]`. The codes are 00 for both edges, 01 for falling only, 10 for rising only and 11 for none.
- R8: Lines named in `INPUT_ONLY_LINES` (bit `n` = line `n`) always read 0 in the direction register, ignore direction writes, and never drive `pin_oe`.
- R9: Offset 0x04 reads zero. Offset 0x18 reads zero in the one-bit variant. All other offsets read zero.
- R10: After reset, every register and `irq` are zero. An event bit sets on the third clock edge after its pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, used with bus_valid |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels, index = line |
| pin_out | output | 32 | Output drive values, index = line |
| pin_oe | output | 32 | Output enables, index = line |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies of the block side by side from one set of stimulus. The first uses the one-bit sense variant with lines 28–31 input-only. The second uses the two-bit variant with lines 0–3 input-only. This covers both generate branches and both ends of the input-only range. Because the two copies interpret the same writes to offsets 0x14 and 0x18 differently, rising-only, falling-only, both-edge and disabled sensing can all be compared in the same cycles. It also shows that offset 0x18 is dead in the one-bit copy.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
  localparam int unsigned GPIO_LINES = 32;

  localparam int unsigned OFS_DIR  = 'h00;
  localparam int unsigned OFS_ODR  = 'h04;
  localparam int unsigned OFS_DAT  = 'h08;
  localparam int unsigned OFS_EVT  = 'h0C;
  localparam int unsigned OFS_MSK  = 'h10;
  localparam int unsigned OFS_CTL  = 'h14;
  localparam int unsigned OFS_CTL2 = 'h18;

  typedef enum logic [1:0] {
    SENSE_ANY  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_OFF  = 2'b11
  } sense_e;

  // Line-ordered vector to register-ordered vector (line n <-> bit 31-n).
  function automatic logic [GPIO_LINES-1:0] line2reg(input logic [GPIO_LINES-1:0] v);
    logic [GPIO_LINES-1:0] r;
    for (int i = 0; i < int'(GPIO_LINES); i++) r[i] = v[GPIO_LINES-1-i];
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync_edge.sv
`timescale 1ns/1ps
module gpio_sync_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;

  // R10: an edge is reported for one cycle only, never twice in a row
  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & $past(rise)) == '0);
  p_single_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall & $past(fall)) == '0);
endmodule

// File: rtl/gpio_edge_qual.sv
`timescale 1ns/1ps
module gpio_edge_qual
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          TWO_BIT = 1'b0
) (
  input  logic [W-1:0] ctl_lo,
  input  logic [W-1:0] ctl_hi,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] qual
);
  localparam int unsigned HALF = W / 2;

  if (TWO_BIT) begin : g_two
    for (genvar b = 0; b < int'(W); b++) begin : g_bit
      sense_e code;
      if (b >= int'(HALF)) begin : g_lo
        assign code = sense_e'(ctl_lo[(b-HALF)*2 +: 2]);
      end else begin : g_hi
        assign code = sense_e'(ctl_hi[b*2 +: 2]);
      end
      always_comb begin
        unique case (code)
          SENSE_ANY:  qual[b] = rise[b] | fall[b];
          SENSE_FALL: qual[b] = fall[b];
          SENSE_RISE: qual[b] = rise[b];
          default:    qual[b] = 1'b0;
        endcase
      end
    end
  end else begin : g_one
    logic unused_hi;
    assign unused_hi = ^ctl_hi;
    for (genvar b = 0; b < int'(W); b++) begin : g_bit
      assign qual[b] = ctl_lo[b] ? fall[b] : (rise[b] | fall[b]);
    end
  end
endmodule

// File: rtl/gpio_event_reg.sv
`timescale 1ns/1ps
module gpio_event_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] evt,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~clr) | qual;
  end

  assign irq = |(evt & mask);

  // R4: a qualified edge always leaves its bit set, even under a clear
  p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(qual) & ~evt) == '0));
  // R4: a bit only appears through an edge or by being held uncleared
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(qual) & ~($past(evt) & ~$past(clr))) == '0));
  // R5: no enabled line, no interrupt
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned           ADDR_W           = 5,
  parameter bit                    TWO_BIT_SENSE    = 1'b0,
  parameter logic [GPIO_LINES-1:0] INPUT_ONLY_LINES = 32'hF000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [GPIO_LINES-1:0] bus_wdata,
  output logic [GPIO_LINES-1:0] bus_rdata,
  input  logic [GPIO_LINES-1:0] pin_in,
  output logic [GPIO_LINES-1:0] pin_out,
  output logic [GPIO_LINES-1:0] pin_oe,
  output logic                  irq
);
  localparam int unsigned W = GPIO_LINES;
  localparam logic [W-1:0] RO_REG = line2reg(INPUT_ONLY_LINES);

  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_ODR  = ADDR_W'(OFS_ODR);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(OFS_CTL2);

  // All internal state is held in register bit order.
  logic [W-1:0] dir_q, dat_q, msk_q, ctl_lo_q, ctl_hi_q;
  logic [W-1:0] pin_r, lvl, rise, fall, qual, evt, clr;

  logic wr;
  logic wr_dir, wr_dat, wr_evt, wr_msk, wr_ctl, wr_ctl2;

  assign wr      = bus_valid & bus_write;
  assign wr_dir  = wr && (bus_addr == A_DIR);
  assign wr_dat  = wr && (bus_addr == A_DAT);
  assign wr_evt  = wr && (bus_addr == A_EVT);
  assign wr_msk  = wr && (bus_addr == A_MSK);
  assign wr_ctl  = wr && (bus_addr == A_CTL);
  assign wr_ctl2 = wr && (bus_addr == A_CTL2) && TWO_BIT_SENSE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      dat_q    <= '0;
      msk_q    <= '0;
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
    end else begin
      if (wr_dir)  dir_q    <= bus_wdata & ~RO_REG;
      if (wr_dat)  dat_q    <= bus_wdata;
      if (wr_msk)  msk_q    <= bus_wdata;
      if (wr_ctl)  ctl_lo_q <= bus_wdata;
      if (wr_ctl2) ctl_hi_q <= bus_wdata;
    end
  end

  assign pin_r = line2reg(pin_in);

  gpio_sync_edge #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (pin_r),
    .level  (lvl),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_edge_qual #(.W(W), .TWO_BIT(TWO_BIT_SENSE)) u_qual (
    .ctl_lo (ctl_lo_q),
    .ctl_hi (ctl_hi_q),
    .rise   (rise),
    .fall   (fall),
    .qual   (qual)
  );

  assign clr = wr_evt ? bus_wdata : '0;

  gpio_event_reg #(.W(W)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .qual  (qual),
    .clr   (clr),
    .mask  (msk_q),
    .evt   (evt),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_ODR:   bus_rdata = '0;
      A_DAT:   bus_rdata = (dir_q & dat_q) | (~dir_q & lvl);
      A_EVT:   bus_rdata = evt;
      A_MSK:   bus_rdata = msk_q;
      A_CTL:   bus_rdata = ctl_lo_q;
      A_CTL2:  bus_rdata = TWO_BIT_SENSE ? ctl_hi_q : '0;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = line2reg(dat_q);
  assign pin_oe  = line2reg(dir_q);

  // R8: input-only lines never drive
  p_input_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & INPUT_ONLY_LINES) == '0);
  // R2: enables move only after a direction write
  p_oe_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir) |-> $stable(pin_oe));
  // R2: drive values move only after a data write
  p_out_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dat) |-> $stable(pin_out));
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  localparam logic [31:0] RO0 = 32'hF000_0000;
  localparam logic [31:0] RO1 = 32'h0000_000F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] rd0, rd1, out0, out1, oe0, oe1;
  logic        irq0, irq1;

  gpio_edge_ctrl #(.ADDR_W(5), .TWO_BIT_SENSE(1'b0), .INPUT_ONLY_LINES(RO0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .pin_in(pin_in), .pin_out(out0), .pin_oe(oe0), .irq(irq0));

  gpio_edge_ctrl #(.ADDR_W(5), .TWO_BIT_SENSE(1'b1), .INPUT_ONLY_LINES(RO1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .pin_in(pin_in), .pin_out(out1), .pin_oe(oe1), .irq(irq1));

  int n_checks = 0, n_errs = 0;
  bit chk_on = 1'b0, done = 1'b0;

  // Behavioural reference, line-indexed (bit n = line n) except raw control words.
  logic [31:0] m_s1, m_s2, m_s3;
  logic [31:0] m_dir [2], m_lat [2], m_msk [2], m_evt [2], m_c1 [2], m_c2 [2];

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic bit sense_ok(input int k, input int n, input bit r, input bit f);
    logic [1:0] code;
    if (k == 0) return m_c1[0][31-n] ? f : (r | f);
    code = (n < 16) ? m_c1[1][(15-n)*2 +: 2] : m_c2[1][(15-(n-16))*2 +: 2];
    case (code)
      2'b00: return r | f;
      2'b01: return f;
      2'b10: return r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int k, input logic [4:0] a);
    logic [31:0] lv;
    case (a)
      5'h00: return flip(m_dir[k]);
      5'h08: begin
        for (int n = 0; n < 32; n++) lv[n] = m_dir[k][n] ? m_lat[k][n] : m_s2[n];
        return flip(lv);
      end
      5'h0C: return flip(m_evt[k]);
      5'h10: return flip(m_msk[k]);
      5'h14: return m_c1[k];
      5'h18: return (k == 1) ? m_c2[k] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int k, input logic [4:0] a);
    case (a)
      5'h00: return "R8";
      5'h08: return "R3";
      5'h0C: return "R4";
      5'h10: return "R5";
      5'h14: return (k == 0) ? "R6" : "R7";
      5'h18: return (k == 0) ? "R9" : "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      for (int k = 0; k < 2; k++) begin
        m_dir[k] = '0; m_lat[k] = '0; m_msk[k] = '0;
        m_evt[k] = '0; m_c1[k] = '0; m_c2[k] = '0;
      end
    end else begin
      logic [31:0] nevt [2];
      bit wr;
      wr = bus_valid && bus_write;
      for (int k = 0; k < 2; k++) begin
        for (int n = 0; n < 32; n++) begin
          bit r, f, c;
          r = m_s2[n] && !m_s3[n];
          f = !m_s2[n] && m_s3[n];
          c = wr && bus_addr == 5'h0C && bus_wdata[31-n];
          nevt[k][n] = (m_evt[k][n] && !c) || sense_ok(k, n, r, f);
        end
      end
      for (int k = 0; k < 2; k++) begin
        m_evt[k] = nevt[k];
        if (wr) begin
          case (bus_addr)
            5'h00: m_dir[k] = flip(bus_wdata) & ~((k == 0) ? RO0 : RO1);
            5'h08: m_lat[k] = flip(bus_wdata);
            5'h10: m_msk[k] = flip(bus_wdata);
            5'h14: m_c1[k]  = bus_wdata;
            5'h18: if (k == 1) m_c2[k] = bus_wdata;
            default: ;
          endcase
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R5", "irq0", {31'h0, irq0}, {31'h0, |(m_evt[0] & m_msk[0])});
      check("R5", "irq1", {31'h0, irq1}, {31'h0, |(m_evt[1] & m_msk[1])});
      check("R2", "oe0", oe0, m_dir[0]);
      check("R2", "oe1", oe1, m_dir[1]);
      check("R2", "out0", out0, m_lat[0]);
      check("R2", "out1", out1, m_lat[1]);
      check(req_of(0, bus_addr), "rdata0", rd0, exp_rd(0, bus_addr));
      check(req_of(1, bus_addr), "rdata1", rd1, exp_rd(1, bus_addr));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e0, input logic [31:0] e1,
                        input string req);
    bus_addr = a;
    #0.5;
    check(req, "read0", rd0, e0);
    check(req, "read1", rd1, e1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(posedge clk); #1;
    chk_on = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10: reset state
    for (int a = 0; a < 8; a++) rd_chk(5'(a * 4), 32'h0, 32'h0, "R10");
    check("R10", "irq after reset", {30'h0, irq1, irq0}, 32'h0);

    // R8: input-only lines
    bus_wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'hFFFF_FFF0, 32'h0FFF_FFFF, "R8");
    check("R8", "oe0 input-only", oe0, 32'h0FFF_FFFF);
    check("R8", "oe1 input-only", oe1, 32'hFFFF_FFF0);

    // R1: bit 31 is line 0
    bus_wr(5'h08, 32'h8000_0000);
    check("R1", "out0 line0", out0, 32'h0000_0001);
    check("R1", "out1 line0", out1, 32'h0000_0001);

    // R3: mixed read-back and synchronizer latency
    bus_wr(5'h00, 32'h0000_FFFF);
    bus_wr(5'h08, 32'hA5A5_3C3C);
    rd_chk(5'h08, 32'h0000_3C30, 32'h0000_3C3C, "R3");
    pin_in = 32'h0000_FFFF;
    tick();
    rd_chk(5'h08, 32'h0000_3C30, 32'h0000_3C3C, "R3");
    tick();
    rd_chk(5'h08, 32'hFFFF_3C30, 32'hFFFF_3C3C, "R3");
    rd_chk(5'h0C, 32'h0, 32'h0, "R10");
    tick();
    rd_chk(5'h0C, 32'hFFFF_0000, 32'hFFFF_0000, "R10");
    check("R5", "irq masked", {30'h0, irq1, irq0}, 32'h0);

    // R5 and R4
    bus_wr(5'h10, 32'h0001_0000);
    check("R5", "irq enabled", {30'h0, irq1, irq0}, 32'h3);
    bus_wr(5'h0C, 32'h0000_FFFF);
    rd_chk(5'h0C, 32'hFFFF_0000, 32'hFFFF_0000, "R4");
    bus_wr(5'h0C, 32'hFFFF_0000);
    rd_chk(5'h0C, 32'h0, 32'h0, "R4");
    check("R5", "irq after clear", {30'h0, irq1, irq0}, 32'h0);

    // R4: edge coincident with its clear keeps the bit
    pin_in = 32'h0000_FFFE;
    tick(); tick();
    bus_wr(5'h0C, 32'h8000_0000);
    rd_chk(5'h0C, 32'h8000_0000, 32'h8000_0000, "R4");

    // R6 / R7 edge sensing
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_wr(5'h18, 32'h5555_5555);
    bus_wr(5'h0C, 32'hFFFF_FFFF);
    pin_in = 32'h0000_FFFF;
    repeat (4) tick();
    rd_chk(5'h0C, 32'h0, 32'h0, "R6");
    pin_in = 32'hFFFF_0000;
    repeat (4) tick();
    rd_chk(5'h0C, 32'hFFFF_0000, 32'h0, "R6");
    pin_in = 32'h0;
    repeat (4) tick();
    rd_chk(5'h0C, 32'hFFFF_FFFF, 32'h0000_FFFF, "R7");
    rd_chk(5'h18, 32'h0, 32'h5555_5555, "R9");
    bus_wr(5'h18, 32'hAAAA_AAAA);
    bus_wr(5'h0C, 32'hFFFF_FFFF);
    pin_in = 32'hFFFF_0000;
    repeat (4) tick();
    rd_chk(5'h0C, 32'h0, 32'h0000_FFFF, "R7");
    rd_chk(5'h04, 32'h0, 32'h0, "R9");
    rd_chk(5'h1C, 32'h0, 32'h0, "R9");

    // Mixed traffic against the reference on every clock
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 8)
        0, 1: begin pin_in = $urandom; tick(); end
        2: bus_wr(5'(($urandom % 8) * 4), $urandom);
        3: bus_wr(5'h0C, $urandom);
        4: bus_wr(5'h14, $urandom);
        5: bus_wr(5'h10, $urandom);
        default: begin bus_addr = 5'(($urandom % 8) * 4); tick(); end
      endcase
    end
    finish_run();
  end
endmodule